// File: doc/BRIEF.md
# Host Byte Staging Buffer for a Two-Wire Bus Master

This block is a small byte store that sits between the register interface of a two-wire (I2C) bus master and its transfer engine. Software pushes a byte by writing one data address and pops the oldest byte by reading the same address. The transfer engine can replace the contents in a single cycle with a burst of received bytes. The block drives two status flags, "holds data" and "full", for the controller status register.

Storage is a shift-down array. A read always returns slot 0, and every valid byte then moves one slot toward the head. A write goes into the slot just above the last valid one.

A fill level from 0 (empty) to DEPTH (full) tracks occupancy. It corresponds to an index running from -1 to DEPTH-1. The two flags are separate registers that change only on the transitions listed below.

Top module: `i2cm_byte_buffer`

## Requirements
- R1: After reset the buffer is empty, both flags are low and `host_rdata` reads 0xFF.
- R2: Bytes written one after another are read back in the order they were written.
- R3: A write while the buffer holds DEPTH (4) bytes is dropped. The full flag stays high and later reads return only the original bytes.
- R4: `host_rdata` presents slot 0 in the cycle `host_rd` is high. The read removes that byte and moves the remaining bytes down one slot.
- R5: A read from an empty buffer returns 0xFF and changes neither the flags nor the contents.
- R6: The holds-data flag rises on a write into an empty buffer and falls on a read that takes the only remaining byte.
- R7: The full flag rises on the write that fills the last slot and falls on the first read from a full buffer. Full never stands without holds-data.
- R8: A flush empties the buffer in one cycle. Both flags go low and all slots become zero.
- R9: A bulk load with count N places byte i of `bulk_data` (bits 8i+7:8i) into slot i for i < N. It sets the level to N and raises holds-data if N >= 1 and full if N >= 4. Counts above 4 are treated as 4.
- R10: A bulk load wins over a flush and over any host access presented in the same cycle.
- R11: A flush wins over host accesses in the same cycle. When read and write strobes arrive together, the read is served and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Single-cycle push strobe |
| host_wdata | input | 8 | Byte to push |
| host_rd | input | 1 | Single-cycle pop strobe |
| host_rdata | output | 8 | Head byte, or 0xFF when empty |
| flush | input | 1 | Empty the buffer and zero all slots |
| bulk_load | input | 1 | Transfer engine loads received bytes |
| bulk_count | input | 3 | Number of bytes in the burst (0 to 7, clamped to 4) |
| bulk_data | input | 32 | Received bytes, byte i at bits 8i+7:8i |
| flag_has_data | output | 1 | Buffer holds at least one byte |
| flag_full | output | 1 | Buffer holds four bytes |

## Verification
A fill-to-overflow-and-drain sequence uses distinct bytes, so ordering errors, a lost shift, or an overflow byte that was wrongly stored each show up as a wrong value at a known read. Bulk loads with every count from 0 to 4, plus one above range, separate the partial, full and clamped cases. They also confirm that only the loaded bytes become readable before 0xFF appears. Same-cycle combinations (load with write, load with flush, flush with write, read with write) each leave a different level and head byte, so a wrong priority is visible.

// File: rtl/i2cm_buf_pkg.sv
package i2cm_buf_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_FLUSH = 3'd3,
    OP_LOAD  = 3'd4
  } buf_op_t;

  // Priority: bulk load, flush, read, write. Reads on empty and writes on full become idle.
  function automatic buf_op_t decode_op(input logic load, input logic flsh,
                                        input logic rd, input logic wr,
                                        input logic is_empty, input logic is_full);
    if (load)      return OP_LOAD;
    if (flsh)      return OP_FLUSH;
    if (rd)        return is_empty ? OP_IDLE : OP_READ;
    if (wr)        return is_full ? OP_IDLE : OP_WRITE;
    return OP_IDLE;
  endfunction

  // Limits a burst count to the buffer depth.
  function automatic int clamp_count(input int cnt, input int depth);
    return (cnt > depth) ? depth : cnt;
  endfunction

endpackage

// File: rtl/i2cm_buf_ctrl.sv
module i2cm_buf_ctrl
  import i2cm_buf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  buf_op_t       op,
  input  logic [LW-1:0] load_n,
  output logic [LW-1:0] level,
  output logic          has_data,
  output logic          full
);
  localparam logic [LW-1:0] LV_FULL = LW'(DEPTH);
  localparam logic [LW-1:0] LV_LAST = LW'(DEPTH - 1);
  localparam logic [LW-1:0] LV_ONE  = LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level    <= '0;
      has_data <= 1'b0;
      full     <= 1'b0;
    end else begin
      unique case (op)
        OP_WRITE: begin
          if (level == '0)     has_data <= 1'b1;
          if (level == LV_LAST) full    <= 1'b1;
          level <= level + LV_ONE;
        end
        OP_READ: begin
          if (level == LV_FULL) full     <= 1'b0;
          if (level == LV_ONE)  has_data <= 1'b0;
          level <= level - LV_ONE;
        end
        OP_FLUSH: begin
          level    <= '0;
          has_data <= 1'b0;
          full     <= 1'b0;
        end
        OP_LOAD: begin
          level    <= load_n;
          has_data <= (load_n != '0);
          full     <= (load_n == LV_FULL);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_buf_store.sv
module i2cm_buf_store
  import i2cm_buf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  buf_op_t          op,
  input  logic [LW-1:0]    level,
  input  logic [LW-1:0]    load_n,
  input  logic [W-1:0]     wdata,
  input  logic [DEPTH*W-1:0] bulk_data,
  output logic [W-1:0]     head
);
  logic [W-1:0] slot [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      unique case (op)
        OP_WRITE: begin
          for (int i = 0; i < DEPTH; i++)
            if (level == LW'(i)) slot[i] <= wdata;
        end
        OP_READ: begin
          for (int i = 0; i < DEPTH - 1; i++) slot[i] <= slot[i+1];
          slot[DEPTH-1] <= '0;
        end
        OP_FLUSH: begin
          for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end
        OP_LOAD: begin
          for (int i = 0; i < DEPTH; i++)
            if (LW'(i) < load_n) slot[i] <= bulk_data[i*W +: W];
        end
        default: ;
      endcase
    end
  end

  assign head = slot[0];
endmodule

// File: rtl/i2cm_byte_buffer.sv
module i2cm_byte_buffer
  import i2cm_buf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [W-1:0]       host_wdata,
  input  logic               host_rd,
  output logic [W-1:0]       host_rdata,
  input  logic               flush,
  input  logic               bulk_load,
  input  logic [LW-1:0]      bulk_count,
  input  logic [DEPTH*W-1:0] bulk_data,
  output logic               flag_has_data,
  output logic               flag_full
);
  buf_op_t       op;
  logic [LW-1:0] level;
  logic [LW-1:0] load_n;
  logic [W-1:0]  head;
  logic          lv_empty, lv_full;
  logic          evt_push, evt_pop, evt_drop;

  assign lv_empty = (level == '0);
  assign lv_full  = (level == LW'(DEPTH));
  assign load_n   = LW'(clamp_count(int'(bulk_count), DEPTH));
  assign op       = decode_op(bulk_load, flush, host_rd, host_wr, lv_empty, lv_full);

  assign evt_push = (op == OP_WRITE);
  assign evt_pop  = (op == OP_READ);
  assign evt_drop = host_wr && !evt_push;

  i2cm_buf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(op), .load_n(load_n),
    .level(level), .has_data(flag_has_data), .full(flag_full)
  );

  i2cm_buf_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .op(op), .level(level), .load_n(load_n),
    .wdata(host_wdata), .bulk_data(bulk_data), .head(head)
  );

  assign host_rdata = lv_empty ? {W{1'b1}} : head;
endmodule

// File: rtl/i2cm_byte_buffer_chk.sv
module i2cm_byte_buffer_chk #(
  parameter int DEPTH = 4,
  parameter int W = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic          host_rd,
  input logic          flush,
  input logic          bulk_load,
  input logic [LW-1:0] bulk_count,
  input logic [W-1:0]  host_rdata,
  input logic          flag_has_data,
  input logic          flag_full,
  input logic [LW-1:0] level,
  input logic          evt_drop
);
  localparam logic [LW-1:0] LV_FULL = LW'(DEPTH);

  assert_empty_read_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && level == '0) |-> host_rdata == {W{1'b1}});

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && flag_full && !host_rd && !flush && !bulk_load)
      |=> (flag_full && level == LV_FULL && $stable(host_rdata)));

  assert_full_implies_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_full |-> flag_has_data);

  assert_flag_tracks_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_has_data == (level != '0));

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !bulk_load) |=> (level == '0 && !flag_has_data && !flag_full));

  assert_load_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_load |=> level == (($past(bulk_count) > LV_FULL) ? LV_FULL : $past(bulk_count)));

  assert_load_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_load && bulk_count >= LV_FULL) |=> flag_full);

  assert_dual_strobe_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_rd) |-> evt_drop);
endmodule

bind i2cm_byte_buffer i2cm_byte_buffer_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .flush(flush), .bulk_load(bulk_load), .bulk_count(bulk_count),
  .host_rdata(host_rdata), .flag_has_data(flag_has_data), .flag_full(flag_full),
  .level(level), .evt_drop(evt_drop)
);

// File: tb/i2cm_byte_buffer_tb.sv
module i2cm_byte_buffer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0, flush = 1'b0, bulk_load = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [2:0]  bulk_count = '0;
  logic [31:0] bulk_data = '0;
  logic [7:0]  host_rdata;
  logic        flag_has_data, flag_full;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  i2cm_byte_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .flush(flush),
    .bulk_load(bulk_load), .bulk_count(bulk_count), .bulk_data(bulk_data),
    .flag_has_data(flag_has_data), .flag_full(flag_full)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_flags(input string req, input bit hd, input bit fu);
    check(req, "has_data", int'(flag_has_data), int'(hd));
    check(req, "full", int'(flag_full), int'(fu));
  endtask

  // One cycle of stimulus; returns the read data seen during it.
  task automatic step(input bit wr, input logic [7:0] wd, input bit rd, input bit fl,
                      input bit ld, input logic [2:0] cnt, input logic [31:0] bd,
                      output logic [7:0] seen);
    @(negedge clk);
    host_wr = wr; host_wdata = wd; host_rd = rd; flush = fl;
    bulk_load = ld; bulk_count = cnt; bulk_data = bd;
    #3 seen = host_rdata;
    @(negedge clk);
    host_wr = 0; host_rd = 0; flush = 0; bulk_load = 0;
  endtask

  task automatic push(input logic [7:0] b);
    logic [7:0] s;
    step(1, b, 0, 0, 0, 0, 0, s);
  endtask

  task automatic pop(output logic [7:0] b);
    step(0, 0, 1, 0, 0, 0, 0, b);
  endtask

  task automatic t_reset;
    check_flags("R1", 0, 0);
    check("R1", "rdata after reset", int'(host_rdata), 'hFF);
  endtask

  task automatic t_fill_drain;
    logic [7:0] b;
    push(8'hA1); check_flags("R6", 1, 0);
    push(8'hA2); push(8'hA3); check_flags("R7", 1, 0);
    push(8'hA4); check_flags("R7", 1, 1);
    push(8'hEE); check_flags("R3", 1, 1);
    pop(b); check("R4", "head 0", int'(b), 'hA1); check_flags("R7", 1, 0);
    pop(b); check("R2", "head 1", int'(b), 'hA2);
    pop(b); check("R2", "head 2", int'(b), 'hA3);
    pop(b); check("R3", "last byte not overflow", int'(b), 'hA4);
    check_flags("R6", 0, 0);
    pop(b); check("R5", "empty read", int'(b), 'hFF);
  endtask

  task automatic t_empty_read;
    logic [7:0] b;
    pop(b); check("R5", "empty read", int'(b), 'hFF); check_flags("R5", 0, 0);
    push(8'h5C); pop(b); check("R5", "after empty read", int'(b), 'h5C);
    check_flags("R6", 0, 0);
  endtask

  task automatic t_flush;
    logic [7:0] b;
    push(8'h11); push(8'h22);
    step(0, 0, 0, 1, 0, 0, 0, b);
    check_flags("R8", 0, 0);
    check("R8", "rdata after flush", int'(host_rdata), 'hFF);
  endtask

  task automatic t_bulk;
    logic [7:0] b;
    for (int n = 0; n <= 5; n++) begin
      int nn = (n == 5) ? 4 : n;
      logic [2:0] cnt = (n == 5) ? 3'd7 : 3'(n);
      step(0, 0, 0, 0, 1, cnt, 32'h4433_2211 + 32'(n), b);
      check_flags("R9", nn >= 1, nn >= 4);
      for (int i = 0; i < nn; i++) begin
        int exp = (i == 0) ? ('h11 + n) : ('h11 * (i + 1));
        pop(b); check("R9", "bulk byte", int'(b), exp);
      end
      pop(b); check("R9", "past bulk end", int'(b), 'hFF);
    end
  endtask

  task automatic t_priority;
    logic [7:0] b;
    push(8'h10);
    step(1, 8'h99, 0, 1, 1, 3'd2, 32'h0000_BBAA, b);
    check_flags("R10", 1, 0);
    pop(b); check("R10", "load beats write", int'(b), 'hAA);
    pop(b); check("R10", "load byte 1", int'(b), 'hBB);
    pop(b); check("R10", "no extra byte", int'(b), 'hFF);
    step(1, 8'h77, 0, 1, 0, 0, 0, b);
    check_flags("R11", 0, 0);
    push(8'h20);
    step(1, 8'h30, 1, 0, 0, 0, 0, b);
    check("R11", "read served", int'(b), 'h20);
    check_flags("R11", 0, 0);
    check("R11", "write dropped", int'(host_rdata), 'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_drain();
    t_empty_read();
    t_flush();
    t_bulk();
    t_priority();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule